// File: doc/BRIEF.md
# Reset-Window Configuration Write Guard

This block stands between a simple register-write bus (address, data, write strobe) and a small group of system configuration registers. It decides, write by write, whether each bit of the target register may change. The decision depends on the target field, on the operating mode latched while reset is held, on whether the field has already taken a write since reset, and on whether the start-up window is still open. The window covers a fixed number of clock cycles after reset is released.

In the normal modes (single-chip and expanded), the fields follow four kinds of rule. Some fields accept exactly one write. Some accept one write and only while the window is open. One register can only have bits cleared, and only while the window is open. The remaining bits are free. In the privileged modes (bootstrap and special test), every protected bit can be written at any time and any number of times. A separate visibility control bit accepts exactly one write in every mode, and its reset value depends on the mode.

Top module: `cfg_write_guard`

## Requirements
- R1: Writes to window-limited fields take effect only on the first 64 rising clock edges after `rst_n` goes high. `win_open_o` is high for exactly those edges and then stays low until the next reset, however long the block runs.
- R2: In modes 00 and 01, bits [1:0] of the timer-mask register (offset 0x10) take the first write after reset, at any time, and ignore all later writes. Bits [7:2] take every write.
- R3: In modes 00 and 01, bits [5:4] and [2:0] of the option register (offset 0x12) take one write, and only inside the window. Bits [7:6] and [3] take every write.
- R4: In modes 00 and 01, the whole map register (offset 0x13) takes one write, and only inside the window.
- R5: In modes 00 and 01, a write to the protect register (offset 0x11) inside the window can only clear bits: the new value is the old value AND the data. Writing a 1 has no effect, and writes outside the window are ignored.
- R6: In mode 10 (bootstrap) and mode 11 (special test), registers 0x10 to 0x13 take every write in full, at any time.
- R7: The visibility bit (bit 0 at offset 0x14) takes exactly one write after reset, in every mode.
- R8: Reset values are timer mask 0x00, option 0x00, protect 0xFF and map 0x01. The visibility bit resets to 1 in mode 11 and to 0 in the other modes.
- R9: The mode is taken from `mode_i` while `rst_n` is low. Changes on `mode_i` after reset is released have no effect until the next reset.
- R10: A write to any offset other than 0x10 to 0x14 leaves every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with `clk` |
| mode_i | input | 2 | Operating mode (00 single-chip, 01 expanded, 10 bootstrap, 11 special test), latched while reset is held |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 8 | Register offset of the write |
| wr_data_i | input | 8 | Write data |
| tmsk_o | output | 8 | Timer-mask register value |
| prot_o | output | 8 | Protect register value |
| opt_o | output | 8 | Option register value |
| map_o | output | 8 | Map register value |
| vis_o | output | 1 | Visibility control bit |
| win_open_o | output | 1 | High while the start-up write window is open |

## Verification
A table of repeated writes in single-chip mode separates the first write from later writes to each field. The same table separates free bits from guarded bits, and setting bits from clearing bits in the protect register. Directed sequences place writes on the 64th and 65th edge after release, to tell a window that closes on time from one that closes a cycle early or late. A write-once field is first written only after the window has closed, to tell the window rule apart from the once-only rule. Repeat writes in bootstrap and special test modes show that both limits are lifted, while the visibility bit stays write-once. A mode change after release, and a write to an unmapped offset, show that neither has any effect.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_EXPAND = 2'b01,
    MODE_BOOT   = 2'b10,
    MODE_TEST   = 2'b11
  } op_mode_e;

  localparam logic [7:0] OFS_TMSK = 8'h10;
  localparam logic [7:0] OFS_PROT = 8'h11;
  localparam logic [7:0] OFS_OPT  = 8'h12;
  localparam logic [7:0] OFS_MAP  = 8'h13;
  localparam logic [7:0] OFS_VIS  = 8'h14;

  // Guarded bit masks, reset values
  localparam logic [7:0] TMSK_GUARD = 8'h03;
  localparam logic [7:0] OPT_GUARD  = 8'h37;
  localparam logic [7:0] ALL_GUARD  = 8'hFF;
  localparam logic [7:0] TMSK_RST   = 8'h00;
  localparam logic [7:0] OPT_RST    = 8'h00;
  localparam logic [7:0] PROT_RST   = 8'hFF;
  localparam logic [7:0] MAP_RST    = 8'h01;

  // Privileged modes lift every write limit except the visibility bit.
  function automatic logic is_priv(op_mode_e m);
    return m[1];
  endfunction

endpackage

// File: rtl/cfg_window_timer.sv
module cfg_window_timer #(
  parameter int WIN_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  output logic win_open_o
);
  localparam int CW = $clog2(WIN_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(WIN_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = (cnt_q != LIMIT);
    cnt_d  = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign win_open_o = (cnt_q < LIMIT);

  // R1: counter saturates at the limit
  p_cnt_sat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);
  // R1: once closed, the window stays closed
  p_win_stays_closed_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !win_open_o |=> !win_open_o);

endmodule

// File: rtl/cfg_guard_field.sv
module cfg_guard_field #(
  parameter int             W          = 8,
  parameter logic [W-1:0]   RST_VAL    = '0,
  parameter logic [W-1:0]   GUARD_MASK = '0,
  parameter bit             ONCE_EN    = 1'b0,
  parameter bit             WIN_EN     = 1'b0,
  parameter bit             CLEAR_ONLY = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         priv_i,
  input  logic         win_open_i,
  input  logic         hit_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] FREE_MASK = ~GUARD_MASK;

  logic [W-1:0] q_q, q_d, guard_val;
  logic         done_q, done_d, gate;

  generate
    if (CLEAR_ONLY) begin : g_clear
      assign guard_val = q_q & data_i;
    end else begin : g_plain
      assign guard_val = data_i;
    end
  endgenerate

  always_comb begin
    gate   = (!ONCE_EN || !done_q) && (!WIN_EN || win_open_i);
    q_d    = q_q;
    done_d = done_q;
    if (priv_i) begin
      q_d    = data_i;
      done_d = 1'b1;
    end else begin
      q_d = (data_i & FREE_MASK) | ((gate ? guard_val : q_q) & GUARD_MASK);
      if (gate) done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q    <= RST_VAL;
      done_q <= 1'b0;
    end else if (hit_i) begin
      q_q    <= q_d;
      done_q <= done_d;
    end
  end

  assign q_o = q_q;

  generate
    if (ONCE_EN) begin : g_a_once
      // R2, R3, R4: after the one accepted write, guarded bits hold in normal modes
      p_once_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!priv_i && done_q) |=> ((q_q & GUARD_MASK) == $past(q_q & GUARD_MASK)));
    end
    if (WIN_EN) begin : g_a_win
      // R3, R4, R5: guarded bits frozen once the window closes in normal modes
      p_win_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!priv_i && !win_open_i) |=> ((q_q & GUARD_MASK) == $past(q_q & GUARD_MASK)));
    end
    if (CLEAR_ONLY) begin : g_a_clr
      // R5: no guarded bit rises in normal modes
      p_clear_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !priv_i |=> ((q_q & ~$past(q_q) & GUARD_MASK) == '0));
    end
  endgenerate

endmodule

// File: rtl/cfg_write_guard.sv
module cfg_write_guard
  import cfg_guard_pkg::*;
#(
  parameter int WIN_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] tmsk_o,
  output logic [7:0] prot_o,
  output logic [7:0] opt_o,
  output logic [7:0] map_o,
  output logic       vis_o,
  output logic       win_open_o
);
  op_mode_e mode_q;
  logic     priv;
  logic     hit_tmsk, hit_prot, hit_opt, hit_map, hit_vis;
  logic     vis_q, vis_d, vis_done_q, vis_en;

  // Mode is captured while reset is held (R9)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= op_mode_e'(mode_i);
  end

  assign priv = is_priv(mode_q);

  always_comb begin
    hit_tmsk = wr_en_i && (wr_addr_i == OFS_TMSK);
    hit_prot = wr_en_i && (wr_addr_i == OFS_PROT);
    hit_opt  = wr_en_i && (wr_addr_i == OFS_OPT);
    hit_map  = wr_en_i && (wr_addr_i == OFS_MAP);
    hit_vis  = wr_en_i && (wr_addr_i == OFS_VIS);
  end

  cfg_window_timer #(.WIN_CYCLES(WIN_CYCLES)) i_timer (
    .clk(clk), .rst_n(rst_n), .win_open_o(win_open_o)
  );

  cfg_guard_field #(.RST_VAL(TMSK_RST), .GUARD_MASK(TMSK_GUARD),
                    .ONCE_EN(1'b1), .WIN_EN(1'b0), .CLEAR_ONLY(1'b0)) i_tmsk (
    .clk(clk), .rst_n(rst_n), .priv_i(priv), .win_open_i(win_open_o),
    .hit_i(hit_tmsk), .data_i(wr_data_i), .q_o(tmsk_o)
  );

  cfg_guard_field #(.RST_VAL(PROT_RST), .GUARD_MASK(ALL_GUARD),
                    .ONCE_EN(1'b0), .WIN_EN(1'b1), .CLEAR_ONLY(1'b1)) i_prot (
    .clk(clk), .rst_n(rst_n), .priv_i(priv), .win_open_i(win_open_o),
    .hit_i(hit_prot), .data_i(wr_data_i), .q_o(prot_o)
  );

  cfg_guard_field #(.RST_VAL(OPT_RST), .GUARD_MASK(OPT_GUARD),
                    .ONCE_EN(1'b1), .WIN_EN(1'b1), .CLEAR_ONLY(1'b0)) i_opt (
    .clk(clk), .rst_n(rst_n), .priv_i(priv), .win_open_i(win_open_o),
    .hit_i(hit_opt), .data_i(wr_data_i), .q_o(opt_o)
  );

  cfg_guard_field #(.RST_VAL(MAP_RST), .GUARD_MASK(ALL_GUARD),
                    .ONCE_EN(1'b1), .WIN_EN(1'b1), .CLEAR_ONLY(1'b0)) i_map (
    .clk(clk), .rst_n(rst_n), .priv_i(priv), .win_open_i(win_open_o),
    .hit_i(hit_map), .data_i(wr_data_i), .q_o(map_o)
  );

  // Visibility bit: write-once in every mode, reset value set by mode (R7, R8)
  always_comb begin
    vis_en = hit_vis && !vis_done_q;
    vis_d  = wr_data_i[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vis_q      <= (op_mode_e'(mode_i) == MODE_TEST);
      vis_done_q <= 1'b0;
    end else if (vis_en) begin
      vis_q      <= vis_d;
      vis_done_q <= 1'b1;
    end
  end

  assign vis_o = vis_q;

  // R7: after the first write the visibility bit never changes
  p_vis_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vis_done_q |=> $stable(vis_q));
  // R9: latched mode holds while out of reset
  p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(mode_q));

endmodule

// File: tb/test_cfg_write_guard.sv
module test_cfg_write_guard;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode_i;
  logic       wr_en_i;
  logic [7:0] wr_addr_i, wr_data_i;
  logic [7:0] tmsk_o, prot_o, opt_o, map_o;
  logic       vis_o, win_open_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  cfg_write_guard i_cfg_write_guard (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .tmsk_o(tmsk_o),
    .prot_o(prot_o), .opt_o(opt_o), .map_o(map_o), .vis_o(vis_o),
    .win_open_o(win_open_o)
  );

  // {write offset, write data, checked offset, expected value}; mode 00, inside window
  localparam logic [31:0] VEC [12] = '{
    32'h10_FF_10_FF,  // R2 first write takes all bits
    32'h10_00_10_03,  // R2 low bits held, upper bits free
    32'h12_FF_12_FF,  // R3 first write
    32'h12_00_12_37,  // R3 guarded bits held, 7:6 and 3 free
    32'h13_5A_13_5A,  // R4 first write
    32'h13_A5_13_5A,  // R4 second write ignored
    32'h11_F0_11_F0,  // R5 clear low nibble
    32'h11_FF_11_F0,  // R5 ones have no effect
    32'h11_3C_11_30,  // R5 further clear
    32'h14_01_14_01,  // R7 first write
    32'h14_00_14_01,  // R7 second write ignored
    32'h20_00_13_5A   // R10 unmapped offset
  };

  function automatic logic [7:0] rd(logic [7:0] a);
    case (a)
      8'h10:   return tmsk_o;
      8'h11:   return prot_o;
      8'h12:   return opt_o;
      8'h13:   return map_o;
      8'h14:   return {7'b0, vis_o};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string req_of(logic [7:0] wa);
    case (wa)
      8'h10:   return "R2";
      8'h11:   return "R5";
      8'h12:   return "R3";
      8'h13:   return "R4";
      8'h14:   return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply_reset(logic [1:0] m);
    @(negedge clk);
    rst_n = 1'b0; mode_i = m; wr_en_i = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Called at a falling edge; consumes exactly one rising edge.
  task automatic do_write(logic [7:0] a, logic [7:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; mode_i = 2'b00; wr_en_i = 1'b0; wr_addr_i = '0; wr_data_i = '0;

    // Reset values, mode 00 (R8, R1)
    apply_reset(2'b00);
    chk("R8", tmsk_o, 8'h00);
    chk("R8", opt_o, 8'h00);
    chk("R8", prot_o, 8'hFF);
    chk("R8", map_o, 8'h01);
    chk("R8", {7'b0, vis_o}, 8'h00);
    chk("R1", {7'b0, win_open_o}, 8'h01);

    for (int i = 0; i < 12; i++) begin
      do_write(VEC[i][31:24], VEC[i][23:16]);
      chk(req_of(VEC[i][31:24]), rd(VEC[i][15:8]), VEC[i][7:0]);
    end

    // R10: unmapped write leaves every output unchanged
    do_write(8'h15, 8'h00);
    chk("R10", tmsk_o, 8'h03);
    chk("R10", prot_o, 8'h30);
    chk("R10", opt_o, 8'h37);
    chk("R10", {7'b0, vis_o}, 8'h01);

    // Window edge: edge 64 accepted, edge 65 rejected (R1, R5)
    apply_reset(2'b01);
    idle(63);
    chk("R1", {7'b0, win_open_o}, 8'h01);
    do_write(8'h11, 8'hFE);
    chk("R1", prot_o, 8'hFE);
    chk("R1", {7'b0, win_open_o}, 8'h00);
    do_write(8'h11, 8'hFC);
    chk("R5", prot_o, 8'hFE);
    do_write(8'h13, 8'h77);
    chk("R4", map_o, 8'h01);
    do_write(8'h12, 8'hFF);
    chk("R3", opt_o, 8'hC8);
    do_write(8'h10, 8'hFF);
    chk("R2", tmsk_o, 8'hFF);
    idle(200);
    chk("R1", {7'b0, win_open_o}, 8'h00);

    // Bootstrap mode: no limits on 0x10..0x13 (R6), visibility still once (R7)
    apply_reset(2'b10);
    chk("R8", {7'b0, vis_o}, 8'h00);
    idle(100);
    do_write(8'h13, 8'h77); do_write(8'h13, 8'h88);
    chk("R6", map_o, 8'h88);
    do_write(8'h11, 8'h00); do_write(8'h11, 8'hFF);
    chk("R6", prot_o, 8'hFF);
    do_write(8'h12, 8'hFF); do_write(8'h12, 8'h00);
    chk("R6", opt_o, 8'h00);
    do_write(8'h10, 8'h01); do_write(8'h10, 8'h02);
    chk("R6", tmsk_o, 8'h02);
    do_write(8'h14, 8'h01); do_write(8'h14, 8'h00);
    chk("R7", {7'b0, vis_o}, 8'h01);

    // Special test mode: visibility resets to 1, once-only
    apply_reset(2'b11);
    chk("R8", {7'b0, vis_o}, 8'h01);
    do_write(8'h14, 8'h00);
    chk("R7", {7'b0, vis_o}, 8'h00);
    do_write(8'h14, 8'h01);
    chk("R7", {7'b0, vis_o}, 8'h00);
    idle(80);
    do_write(8'h11, 8'h00); do_write(8'h11, 8'h5A);
    chk("R6", prot_o, 8'h5A);

    // R9: mode change after release has no effect
    apply_reset(2'b00);
    mode_i = 2'b11;
    do_write(8'h13, 8'h12);
    do_write(8'h13, 8'h34);
    chk("R9", map_o, 8'h12);
    chk("R9", {7'b0, vis_o}, 8'h00);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule